// File: doc/BRIEF.md
# Receive Buffer with Character Error Tracking

This block is the receive-side character buffer of a serial port. The deserializer pushes each received byte into it. Each byte comes with its break, framing and parity flags and with a line-overrun indication. Software drains the buffer through a data-register read strobe and polls or takes interrupts through a status-register read strobe.

The flags of the character at the head of the buffer are presented next to its data. They move with the head, so software always sees the condition of the byte it is about to read.

A separate summary bit tells software that at least one stored character, not necessarily the head, was received with an error. That bit comes from a running tally of erroneous entries: the tally rises on every accepted push of a flagged character and falls on every pop of one. No scan of the storage is needed.

Overrun is kept apart from the per-character flags as a sticky bit. The summary bit and the overrun bit together form the line-status interrupt request.

Top module: `rx_err_fifo`

## Requirements
- R1: One cycle after an accepted write whose break, framing or parity flag is set, `err_any` is 1.
- R2: `err_any` is 1 exactly while at least one stored entry has any error flag set. It falls only in the cycle after the last such entry is popped.
- R3: While the buffer is non-empty, `head_data`, `head_brk`, `head_fe` and `head_pe` show the oldest stored entry, in write order.
- R4: A data read on a non-empty buffer removes the head. From the next cycle the head outputs show the following entry.
- R5: While the buffer is empty, `head_data`, `head_brk`, `head_fe` and `head_pe` are all 0.
- R6: `data_ready` is 1 exactly while the buffer holds at least one entry.
- R7: `ovr_flag` is set in the cycle after `wr_ovr` is 1 or a write is dropped. It is cleared in the cycle after a status read. If set and clear arrive in the same cycle, the set wins.
- R8: The buffer holds DEPTH entries (default 64). A write while it is full and not being read is dropped, and the stored contents are unchanged. A write that arrives together with a read of a full buffer is accepted.
- R9: `lsi_req` equals `err_any` OR `ovr_flag`.
- R10: A write and a read in the same cycle on a non-empty buffer leave the occupancy unchanged. They keep the error tally consistent with the stored entries.
- R11: After reset the buffer is empty, `ovr_flag`, `err_any` and `lsi_req` are 0, and all head outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Deserializer delivers a character |
| wr_data | input | DATA_W | Received byte |
| wr_brk | input | 1 | Break detected on this character |
| wr_fe | input | 1 | Framing error on this character |
| wr_pe | input | 1 | Parity error on this character |
| wr_ovr | input | 1 | Deserializer reports a lost character |
| rd_data_en | input | 1 | Data-register read strobe (pops the head) |
| rd_status_en | input | 1 | Status-register read strobe (clears overrun) |
| head_data | output | DATA_W | Byte at the head, 0 when empty |
| head_brk | output | 1 | Break flag of the head character |
| head_fe | output | 1 | Framing flag of the head character |
| head_pe | output | 1 | Parity flag of the head character |
| err_any | output | 1 | Some stored character has an error |
| ovr_flag | output | 1 | Sticky overrun |
| data_ready | output | 1 | Buffer non-empty |
| lsi_req | output | 1 | Line-status interrupt request |

## Verification
The assertions take for granted that the strobes are single-cycle, synchronous pulses. They also take for granted that a data read on an empty buffer or a write on a full one may occur and must be tolerated rather than excluded. The stimulus therefore includes reads of an empty buffer, writes into a full buffer, and strobes that collide in one cycle. It also includes long pseudo-random mixes in which every combination of the three flags appears. The bench drives the strobes only between clock edges and holds them for exactly one cycle. All inputs stay within single-cycle strobe use, which is the only input discipline the block assumes.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_flags_t;

  function automatic logic flags_bad(rx_flags_t f);
    return f.brk | f.fe | f.pe;
  endfunction
endpackage

// File: rtl/rxf_storage.sv
module rxf_storage
  import rx_err_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] in_data,
  input  rx_flags_t         in_flags,
  output logic [DATA_W-1:0] out_data,
  output rx_flags_t         out_flags,
  output logic [CW-1:0]     occ,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem_data [DEPTH];
  rx_flags_t         mem_flag [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] occ_next(logic [CW-1:0] c, logic inc, logic dec);
    case ({inc, dec})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem_data[wr_ptr] <= in_data;
      mem_flag[wr_ptr] <= in_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      occ <= occ_next(occ, push, pop);
    end
  end

  assign full      = (occ == CW'(DEPTH));
  assign empty     = (occ == '0);
  assign out_data  = mem_data[rd_ptr];
  assign out_flags = mem_flag[rd_ptr];

  // R8: occupancy never exceeds the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  // R8: no push into a full buffer unless a pop frees a slot
  a_r8_full_guard: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(push && !pop));
  // R4: a pop is never issued on an empty buffer
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  // R10: simultaneous push and pop leaves occupancy unchanged
  a_r10_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(occ));
endmodule

// File: rtl/rxf_err_tally.sv
module rxf_err_tally #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_bad,
  input  logic          pop,
  input  logic          pop_bad,
  input  logic [CW-1:0] occ,
  output logic          err_any
);
  logic [CW-1:0] bad_cnt;
  logic          inc_ev, dec_ev;

  assign inc_ev = push & push_bad;
  assign dec_ev = pop & pop_bad;

  function automatic logic [CW-1:0] tally_next(logic [CW-1:0] c, logic inc, logic dec);
    case ({inc, dec})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_cnt <= '0;
    else        bad_cnt <= tally_next(bad_cnt, inc_ev, dec_ev);
  end

  assign err_any = (bad_cnt != '0);

  // R10: tally never exceeds the number of stored entries
  a_r10_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt <= occ);
  // R1: an accepted erroneous push raises the summary bit
  a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |=> err_any);
  // R2: the summary bit falls only after an erroneous entry leaves
  a_r2_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_any) |-> $past(dec_ev));
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rx_err_fifo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ovr,
  input  logic              status_rd,
  input  logic              empty,
  input  logic [DATA_W-1:0] raw_data,
  input  rx_flags_t         raw_flags,
  input  logic              err_any,
  output logic [DATA_W-1:0] head_data,
  output rx_flags_t         head_flags,
  output logic              ovr_flag,
  output logic              lsi_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_flag <= 1'b0;
    else if (set_ovr)   ovr_flag <= 1'b1;
    else if (status_rd) ovr_flag <= 1'b0;
  end

  assign head_data  = empty ? '0 : raw_data;
  assign head_flags = empty ? '0 : raw_flags;
  assign lsi_req    = err_any | ovr_flag;

  // R7: overrun clears only after a status read
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag) |-> $past(status_rd));
  // R7: a set request always leaves the flag high
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovr |=> ovr_flag);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_brk,
  input  logic              wr_fe,
  input  logic              wr_pe,
  input  logic              wr_ovr,
  input  logic              rd_data_en,
  input  logic              rd_status_en,
  output logic [DATA_W-1:0] head_data,
  output logic              head_brk,
  output logic              head_fe,
  output logic              head_pe,
  output logic              err_any,
  output logic              ovr_flag,
  output logic              data_ready,
  output logic              lsi_req
);
  localparam int CW = $clog2(DEPTH + 1);

  rx_flags_t         in_flags, raw_flags, hd_flags;
  logic [DATA_W-1:0] raw_data;
  logic [CW-1:0]     occ;
  logic              full, empty;
  logic              pop_ev, push_ev, drop_ev, set_ovr;

  assign in_flags = '{brk: wr_brk, fe: wr_fe, pe: wr_pe};
  assign pop_ev   = rd_data_en & ~empty;
  assign push_ev  = wr_en & (~full | pop_ev);
  assign drop_ev  = wr_en & ~push_ev;
  assign set_ovr  = drop_ev | wr_ovr;

  rxf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .pop(pop_ev),
    .in_data(wr_data), .in_flags(in_flags),
    .out_data(raw_data), .out_flags(raw_flags),
    .occ(occ), .full(full), .empty(empty)
  );

  rxf_err_tally #(.DEPTH(DEPTH)) u_tally (
    .clk(clk), .rst_n(rst_n),
    .push(push_ev), .push_bad(flags_bad(in_flags)),
    .pop(pop_ev), .pop_bad(flags_bad(raw_flags)),
    .occ(occ), .err_any(err_any)
  );

  rxf_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_ovr(set_ovr), .status_rd(rd_status_en),
    .empty(empty), .raw_data(raw_data), .raw_flags(raw_flags),
    .err_any(err_any), .head_data(head_data), .head_flags(hd_flags),
    .ovr_flag(ovr_flag), .lsi_req(lsi_req)
  );

  assign head_brk   = hd_flags.brk;
  assign head_fe    = hd_flags.fe;
  assign head_pe    = hd_flags.pe;
  assign data_ready = ~empty;

  // R5: an empty buffer shows clean head flags
  a_r5_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> !(head_brk | head_fe | head_pe));
  // R2: a flagged head implies the summary bit is set
  a_r2_head_covered: assert property (@(posedge clk) disable iff (!rst_n)
    (head_brk | head_fe | head_pe) |-> err_any);
  // R8: a dropped write leaves the data-ready state unchanged
  a_r8_drop_ready: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> data_ready);
  // R9: request follows its two sources
  a_r9_request: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any | ovr_flag) |-> lsi_req);
endmodule

// File: tb/rx_err_fifo_bench.sv
module rx_err_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, wr_brk = 0, wr_fe = 0, wr_pe = 0, wr_ovr = 0;
  logic [7:0] wr_data = '0;
  logic       rd_data_en = 0, rd_status_en = 0;
  logic [7:0] head_data;
  logic       head_brk, head_fe, head_pe, err_any, ovr_flag, data_ready, lsi_req;

  int n_checks = 0;
  int n_fail   = 0;
  logic [10:0] mq[$];
  logic        m_ovr = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_fifo u_rx_err_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_brk(wr_brk), .wr_fe(wr_fe), .wr_pe(wr_pe), .wr_ovr(wr_ovr),
    .rd_data_en(rd_data_en), .rd_status_en(rd_status_en),
    .head_data(head_data), .head_brk(head_brk), .head_fe(head_fe),
    .head_pe(head_pe), .err_any(err_any), .ovr_flag(ovr_flag),
    .data_ready(data_ready), .lsi_req(lsi_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model_bad();
    for (int i = 0; i < mq.size(); i++)
      if (mq[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_all(input logic popped, input logic pushed_bad);
    logic [10:0] h;
    logic        e;
    h = (mq.size() > 0) ? mq[0] : 11'h0;
    e = model_bad();
    if (mq.size() == 0)
      chk("R5 head empty", {head_brk, head_fe, head_pe, head_data}, 0);
    else if (popped)
      chk("R4 head after pop", {head_brk, head_fe, head_pe, head_data}, h);
    else
      chk("R3 head entry", {head_brk, head_fe, head_pe, head_data}, h);
    chk("R6 data_ready", data_ready, mq.size() > 0);
    if (pushed_bad) chk("R1 err_any after bad push", err_any, 1);
    chk("R2 err_any", err_any, e);
    chk("R7 ovr_flag", ovr_flag, m_ovr);
    chk("R9 lsi_req", lsi_req, e | m_ovr);
  endtask

  // flags f = {brk, fe, pe}
  task automatic step(input logic w, input logic [7:0] d, input logic [2:0] f,
                      input logic ov, input logic rd, input logic rs);
    logic pop, acc, bad;
    wr_en = w; wr_data = d; {wr_brk, wr_fe, wr_pe} = f;
    wr_ovr = ov; rd_data_en = rd; rd_status_en = rs;
    @(posedge clk);
    pop = rd && (mq.size() > 0);
    acc = w && ((mq.size() < DEPTH) || pop);
    bad = acc && (f != 3'b000);
    if (pop) void'(mq.pop_front());
    if (acc) mq.push_back({f, d});
    if ((w && !acc) || ov) m_ovr = 1'b1;
    else if (rs)           m_ovr = 1'b0;
    @(negedge clk);
    wr_en = 0; wr_ovr = 0; rd_data_en = 0; rd_status_en = 0;
    check_all(pop, bad);
  endtask

  task automatic lfsr_adv();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int pops;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 reset head", {head_brk, head_fe, head_pe, head_data}, 0);
    chk("R11 reset status", {err_any, ovr_flag, data_ready, lsi_req}, 0);

    // Read of empty buffer has no effect
    step(0, 8'h00, 3'b000, 0, 1, 0);

    // Sweep every flag combination, one at a time through the buffer
    for (int f = 0; f < 8; f++) begin
      step(1, 8'(8'h30 + f), 3'(f), 0, 0, 0);
      step(1, 8'(8'hA0 + f), 3'b000, 0, 0, 0);
      step(0, 8'h00, 3'b000, 0, 1, 0);
      step(0, 8'h00, 3'b000, 0, 1, 0);
    end

    // Errors deep in the buffer: clean head, flagged tail
    for (int i = 0; i < 10; i++) step(1, 8'(i), (i == 7) ? 3'b100 : 3'b000, 0, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 8'h00, 3'b000, 0, 1, 0);

    // R8: fill to full, drop a write, drain and count
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 3), 3'(i % 8), 0, 0, 0);
    step(1, 8'hEE, 3'b111, 0, 0, 0);
    step(1, 8'hEF, 3'b000, 0, 0, 1);  // drop and status read in one cycle: set wins
    // full with simultaneous read and write: accepted
    step(1, 8'h5A, 3'b010, 0, 1, 0);
    step(0, 8'h00, 3'b000, 0, 0, 1);
    pops = 0;
    while (data_ready && pops < DEPTH + 4) begin
      step(0, 8'h00, 3'b000, 0, 1, 0);
      pops++;
    end
    chk("R8 entries held at full", pops, DEPTH);

    // R7: overrun input from deserializer, collision with status read
    step(0, 8'h00, 3'b000, 1, 0, 1);
    step(0, 8'h00, 3'b000, 0, 0, 1);
    step(0, 8'h00, 3'b000, 1, 0, 0);
    step(0, 8'h00, 3'b000, 0, 0, 1);

    // R10: balanced traffic keeps occupancy and tally consistent
    for (int i = 0; i < 5; i++) step(1, 8'(8'h70 + i), 3'(i), 0, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 8'(8'h90 + i), 3'(i % 3), 0, 1, 0);
    pops = 0;
    while (data_ready && pops < DEPTH + 4) begin
      step(0, 8'h00, 3'b000, 0, 1, 0);
      pops++;
    end
    chk("R10 occupancy after balanced traffic", pops, 5);

    // Pseudo-random mix of everything
    for (int i = 0; i < 4000; i++) begin
      lfsr_adv();
      step(lfsr[0] | lfsr[1], lfsr[15:8], (lfsr[4:2] == 3'b011) ? lfsr[7:5] : 3'b000,
           lfsr[9] & lfsr[10] & lfsr[11] & lfsr[12],
           (i % 1000 < 500) ? (lfsr[3] & lfsr[6]) : (lfsr[3] | lfsr[6]),
           lfsr[13] & lfsr[14]);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule